// File: doc/BRIEF.md
# RAM Port Clear Sequencer

This block sits in front of one port of a synchronous single-port RAM and can fill the whole array with one value under hardware control. When the block is idle, the user's address, write data, write enable and read enable reach the RAM through a selection multiplexer. A one-cycle clear request starts an address sweep that writes a fill value into every location from 0 to `DEPTH-1`, one location per clock.

The fill value comes from an input and is latched when the sweep starts. While the sweep runs, a busy flag is high and user reads and writes are blocked from the RAM. Logic that drives other ports of the same array can AND its write enables with the inverse of the busy flag so that it stays out of the way during a sweep.

The RAM model is an inferred array inside the block. A synchronous reset returns the sequencer to idle and leaves the array contents alone.

Top module: `ram_clear_seq`

## Requirements
- R1: After reset, `clearBusy` is 0 and `rdData` is 0.
- R2: If `clearReq` is sampled high while idle, `clearBusy` is 1 in the next cycle.
- R3: `clearBusy` stays high for exactly `DEPTH` consecutive cycles and then falls.
- R4: When a sweep completes, every address from 0 to `DEPTH-1` holds the fill value.
- R5: The fill value is the value of `clearTo` sampled on the same edge as the clear request. Later changes to `clearTo` during the sweep have no effect.
- R6: A user write presented while `clearBusy` is high does not modify memory.
- R7: A user read presented while `clearBusy` is high is not performed, and `rdData` holds its previous value.
- R8: A `clearReq` that arrives while `clearBusy` is high is ignored, so the running sweep neither restarts nor lengthens.
- R9: While idle, a user write with `usrWe`=1 stores `usrWrData` at `usrAddr`. A user read with `usrRe`=1 presents the stored word on `rdData` one cycle later.
- R10: Reset during a sweep returns the block to idle and performs no sweep write in the reset cycle. Locations already swept keep the fill value, and the other locations keep their old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clearReq | input | 1 | Starts a sweep when sampled high while idle |
| clearTo | input | DATA_W | Fill value, latched at sweep start |
| usrAddr | input | ADDR_W | User address |
| usrWrData | input | DATA_W | User write data |
| usrWe | input | 1 | User write enable |
| usrRe | input | 1 | User read enable |
| rdData | output | DATA_W | Registered read data |
| clearBusy | output | 1 | High while a sweep is running |

## Verification
Three input patterns are used. First, a distinct arithmetic pattern (7·a+3) is written to every address and read back, which shows that idle pass-through works and that every address decodes separately. Next, a full sweep runs while the bench holds several inputs against it: a competing write of 0xEE to address 0 (already swept) for the whole sweep, a changed `clearTo`, a second clear request in the middle, and an active read. Reading back 0xA5 everywhere tells a correct sweep apart from a leaked write, a late fill capture or a restarted sweep. Finally, a reset after three swept addresses gives a split pattern (fill value below address 3, old contents from 3 upward), which separates an abort that is handled correctly from one that writes in the reset cycle or loses the array.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  typedef enum logic {ST_IDLE, ST_CLEAR} rcsState_t;

  typedef struct packed {
    logic capture;   // latch fill value
    logic cntClr;    // zero the sweep counter
    logic cntInc;    // advance the sweep counter
    logic selSweep;  // RAM port driven by the sweep
  } rcsStrobe_t;
endpackage

// File: rtl/rcs_ctrl.sv
module rcs_ctrl
  import rcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clearReq,
  input  logic       lastAddr,
  output rcsStrobe_t strobe,
  output logic       busy
);
  rcsState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_IDLE:  if (clearReq) stateNxt = ST_CLEAR;
      ST_CLEAR: if (lastAddr) stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNxt;
  end

  always_comb begin
    strobe = '0;
    if (!rst) begin
      case (state)
        ST_IDLE: begin
          strobe.capture = clearReq;
          strobe.cntClr  = clearReq;
        end
        ST_CLEAR: begin
          strobe.cntInc   = 1'b1;
          strobe.selSweep = 1'b1;
        end
        default: strobe = '0;
      endcase
    end
  end

  assign busy = (state == ST_CLEAR);

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && clearReq) |=> busy);
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && !lastAddr) |=> busy);
  p_end_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && lastAddr) |=> !busy);
  p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !strobe.capture);
endmodule

// File: rtl/rcs_datapath.sv
module rcs_datapath
  import rcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  rcsStrobe_t        strobe,
  input  logic [DATA_W-1:0] clearTo,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic [DATA_W-1:0] usrWrData,
  input  logic              usrWe,
  input  logic              usrRe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWrData,
  output logic              ramWe,
  output logic              ramRe,
  output logic              lastAddr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] sweepCnt;
  logic [DATA_W-1:0] fillReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sweepCnt <= '0;
      fillReg  <= '0;
    end else begin
      if (strobe.cntClr)
        sweepCnt <= '0;
      else if (strobe.cntInc)
        sweepCnt <= (sweepCnt == LAST_ADDR) ? '0 : sweepCnt + ADDR_W'(1);
      if (strobe.capture)
        fillReg <= clearTo;
    end
  end

  assign lastAddr = (sweepCnt == LAST_ADDR);

  // port selection multiplexer
  always_comb begin
    if (strobe.selSweep) begin
      ramAddr   = sweepCnt;
      ramWrData = fillReg;
      ramWe     = 1'b1;
      ramRe     = 1'b0;
    end else begin
      ramAddr   = usrAddr;
      ramWrData = usrWrData;
      ramWe     = usrWe;
      ramRe     = usrRe;
    end
  end

  p_fill_hold_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.selSweep |=> $stable(fillReg));
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (strobe.cntInc && !lastAddr) |=> (sweepCnt == $past(sweepCnt) + ADDR_W'(1)));
  p_block_wr_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe.selSweep && usrWe) |-> (ramWrData == fillReg));
  p_block_rd_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.selSweep && usrRe) |-> !ramRe);
endmodule

// File: rtl/rcs_mem.sv
module rcs_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) memArr[addr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdData <= '0;
    else if (re) rdData <= memArr[addr];
  end

  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdData));
endmodule

// File: rtl/ram_clear_seq.sv
module ram_clear_seq
  import rcs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clearReq,
  input  logic [DATA_W-1:0] clearTo,
  input  logic [ADDR_W-1:0] usrAddr,
  input  logic [DATA_W-1:0] usrWrData,
  input  logic              usrWe,
  input  logic              usrRe,
  output logic [DATA_W-1:0] rdData,
  output logic              clearBusy
);
  rcsStrobe_t        strobe;
  logic              lastAddr;
  logic [ADDR_W-1:0] ramAddr;
  logic [DATA_W-1:0] ramWrData;
  logic              ramWe;
  logic              ramRe;

  rcs_ctrl ctrl_i (
    .clk(clk), .rst(rst), .clearReq(clearReq), .lastAddr(lastAddr),
    .strobe(strobe), .busy(clearBusy)
  );

  rcs_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .clearTo(clearTo),
    .usrAddr(usrAddr), .usrWrData(usrWrData), .usrWe(usrWe), .usrRe(usrRe),
    .ramAddr(ramAddr), .ramWrData(ramWrData), .ramWe(ramWe), .ramRe(ramRe),
    .lastAddr(lastAddr)
  );

  rcs_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
    .clk(clk), .rst(rst), .addr(ramAddr), .wrData(ramWrData),
    .we(ramWe), .re(ramRe), .rdData(rdData)
  );
endmodule

// File: tb/ram_clear_seq_tb_top.sv
module ram_clear_seq_tb_top;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              clearReq = 1'b0;
  logic [DATA_W-1:0] clearTo = '0;
  logic [ADDR_W-1:0] usrAddr = '0;
  logic [DATA_W-1:0] usrWrData = '0;
  logic              usrWe = 1'b0;
  logic              usrRe = 1'b0;
  logic [DATA_W-1:0] rdData;
  logic              clearBusy;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ram_clear_seq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .clearReq(clearReq), .clearTo(clearTo),
    .usrAddr(usrAddr), .usrWrData(usrWrData), .usrWe(usrWe), .usrRe(usrRe),
    .rdData(rdData), .clearBusy(clearBusy)
  );

  function automatic logic [DATA_W-1:0] pat(int a);
    return DATA_W'(a * 7 + 3);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    usrAddr = ADDR_W'(a); usrWrData = d; usrWe = 1'b1;
    @(negedge clk);
    usrWe = 1'b0;
  endtask

  task automatic rd(int a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    usrAddr = ADDR_W'(a); usrRe = 1'b1;
    @(negedge clk);
    usrRe = 1'b0;
    d = rdData;
  endtask

  initial begin
    logic [DATA_W-1:0] v;
    logic [DATA_W-1:0] prevRd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 busy", 32'(clearBusy), 0);
    check("R1 rdData", 32'(rdData), 0);

    // R9 pass-through with distinct pattern
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a));
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      check("R9 readback", 32'(v), 32'(pat(a)));
    end

    // sweep with fill 0xA5 while competing inputs are applied
    @(negedge clk);
    clearTo = 8'hA5; clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    check("R2 busy rises", 32'(clearBusy), 1);
    prevRd = rdData;
    clearTo = 8'h3C;                                       // R5
    usrAddr = '0; usrWrData = 8'hEE; usrWe = 1'b1;         // R6
    usrRe = 1'b1;                                          // R7
    for (int i = 1; i < DEPTH; i++) begin
      @(negedge clk);
      check("R3 busy held", 32'(clearBusy), 1);
      check("R7 rdData held", 32'(rdData), 32'(prevRd));
      clearReq = (i == 5);                                 // R8
    end
    @(negedge clk);
    check("R3/R8 busy falls", 32'(clearBusy), 0);
    usrWe = 1'b0; usrRe = 1'b0; clearReq = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      check("R4/R5/R6 fill", 32'(v), 32'hA5);
    end

    // R10 reset mid-sweep: restore pattern, sweep with 0x00, abort after 3 writes
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a));
    @(negedge clk);
    clearTo = 8'h00; clearReq = 1'b1;
    @(negedge clk);
    clearReq = 1'b0;
    check("R2 busy rises again", 32'(clearBusy), 1);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 idle after reset", 32'(clearBusy), 0);
    for (int a = 0; a < DEPTH; a++) begin
      rd(a, v);
      check("R10 contents", 32'(v), (a < 3) ? 32'h0 : 32'(pat(a)));
    end
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule